// File: doc/BRIEF.md
# Tuner Control Two-Wire Target

This block is the register-access front end of a frequency-synthesizer tuner. A host on an I2C bus addresses it, writes the 15-bit loop divider ratio and a set of tuning controls, and reads back one status byte. Both bus lines are brought into the system clock domain through two-flop synchronizers and a stability filter. Start and stop conditions, clock edges and data bits are all recognised on those filtered copies. The only drive onto the bus is an open-drain pull-down enable for SDA.

A write carries its data as byte pairs. The top bit of the first byte of each pair picks the destination: the divider register or the control register. A register is updated only when the second byte of its pair has arrived. A read returns the status byte repeatedly for as long as the host acknowledges. A read that ends with the host's not-acknowledge clears the power-on flag. The two low address bits come from a strap input, so up to four such targets can share one bus.

Top module: `tuner_i2c_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal binary 11000 followed by strap_addr[1:0]. For any other address it never pulls SDA low and changes no register until the next start.
- R2: While rst is high, sda_drive_low is 0. After reset, div_ratio and all control outputs are 0 and the power-on flag is 1.
- R3: In a write, a pair whose first byte has bit 7 equal to 0 is a divider pair. First-byte bits 6:0 become div_ratio[14:8] and the second byte becomes div_ratio[7:0].
- R4: A pair whose first byte has bit 7 equal to 1 is a control pair. First-byte bit 6 sets pump_hi, bits 5:4 set test_mode[1:0] and bit 0 sets tune_off. Second-byte bit 7 sets band_uhf and bits 2:0 set port_drv[2:0].
- R5: One write may carry a divider pair and a control pair in either order, and both take effect.
- R6: A register changes only when the second byte of its pair completes. A stop or start after a lone first byte leaves every register unchanged.
- R7: An addressed target pulls SDA low during the ninth clock of the address byte and of every written data byte. The pull-down starts only while SCL is low.
- R8: After a read address, the target shifts out the status byte MSB first: power-on flag, lock_in, 0, ttl_in[1], ttl_in[0], adc_code[2:0]. It sends the status byte again after each host acknowledge.
- R9: A host not-acknowledge ends the read: SDA is released and the power-on flag reads 0 in the next read.
- R10: A one-cycle pulse on supply_low sets the power-on flag again.
- R11: An SCL or SDA pulse shorter than the filter window (3 system clocks) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, also the power-on reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| strap_addr | input | 2 | Low two address bits from the strap decoder |
| supply_low | input | 1 | Supply-low event; sets the power-on flag |
| lock_in | input | 1 | Loop lock indication |
| ttl_in | input | 2 | Two logic-level port inputs |
| adc_code | input | 3 | Level code from the port converter |
| div_ratio | output | 15 | Programmed divider ratio |
| pump_hi | output | 1 | High charge-pump current select |
| test_mode | output | 2 | Two test control bits |
| tune_off | output | 1 | Disables the tuning-voltage output |
| band_uhf | output | 1 | Band select, 1 for the upper band |
| port_drv | output | 3 | Open-collector port output enables |

## Verification
The assertions assume a well-formed host. It changes SDA only while SCL is low, except to make a start or a stop. It holds every SCL level far longer than the filter window, and it never pulls SDA low at the same time as the target. The bench host keeps each SCL phase at 20 system clocks and moves SDA in the middle of the low phase. It releases the line whenever it expects the target to drive. The one deliberate departure is a single-clock SCL pulse that checks the filter. That pulse stays well inside a low phase, so it never touches a real edge.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

    localparam int DIV_W = 15;
    localparam int STRAP_W = 2;
    localparam logic [4:0] DEV_PREFIX = 5'b11000;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_WRITE,
        LK_READ,
        LK_SKIP
    } link_state_t;

    typedef struct packed {
        logic       pump_hi;
        logic [1:0] test_mode;
        logic       tune_off;
        logic       band_uhf;
        logic [2:0] port_drv;
    } tune_ctrl_t;

    function automatic logic [7:0] pack_status(logic por, logic lock,
                                               logic [1:0] ttl, logic [2:0] adc);
        return {por, lock, 1'b0, ttl, adc};
    endfunction

endpackage

// File: rtl/tuner_i2c_deglitch.sv
module tuner_i2c_deglitch #(
    parameter int   STABLE_CYC = 3,
    parameter logic IDLE_VAL   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= {2{IDLE_VAL}};
            clean   <= IDLE_VAL;
            run_cnt <= '0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == clean) begin
                run_cnt <= '0;
            end else if (run_cnt == CW'(STABLE_CYC - 1)) begin
                clean   <= sync_q[1];
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + CW'(1);
            end
        end
    end
endmodule

// File: rtl/tuner_i2c_link.sv
module tuner_i2c_link
    import tuner_i2c_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               scl,
    input  logic               sda,
    input  logic [STRAP_W-1:0] strap,
    input  logic [7:0]         status,
    output logic               sda_low,
    output logic               wr_valid,
    output logic [7:0]         wr_byte,
    output logic               frame_mark,
    output logic               read_end,
    output link_state_t        state
);
    logic       scl_q, sda_q;
    logic [3:0] bitcnt;
    logic [6:0] shreg;
    logic       ack_pend;
    logic [7:0] tx;

    logic scl_rise, scl_fall, start_det, stop_det;
    always_comb begin
        scl_rise  = scl & ~scl_q;
        scl_fall  = ~scl & scl_q;
        start_det = scl & scl_q & sda_q & ~sda;
        stop_det  = scl & scl_q & ~sda_q & sda;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= LK_IDLE;
            scl_q      <= 1'b1;
            sda_q      <= 1'b1;
            bitcnt     <= '0;
            shreg      <= '0;
            ack_pend   <= 1'b0;
            tx         <= '0;
            sda_low    <= 1'b0;
            wr_valid   <= 1'b0;
            wr_byte    <= '0;
            frame_mark <= 1'b0;
            read_end   <= 1'b0;
        end else begin
            wr_valid   <= 1'b0;
            frame_mark <= 1'b0;
            read_end   <= 1'b0;
            scl_q      <= scl;
            sda_q      <= sda;
            if (start_det) begin
                state      <= LK_ADDR;
                bitcnt     <= '0;
                sda_low    <= 1'b0;
                ack_pend   <= 1'b0;
                frame_mark <= 1'b1;
            end else if (stop_det) begin
                state      <= LK_IDLE;
                sda_low    <= 1'b0;
                ack_pend   <= 1'b0;
                frame_mark <= 1'b1;
            end else if (state == LK_IDLE || state == LK_SKIP) begin
                sda_low <= 1'b0;
            end else if (scl_rise) begin
                if (bitcnt == 4'd8) begin
                    bitcnt <= '0;
                    if (state == LK_READ && sda) begin
                        state    <= LK_SKIP;
                        read_end <= 1'b1;
                    end
                end else begin
                    shreg  <= {shreg[5:0], sda};
                    bitcnt <= bitcnt + 4'd1;
                    if (bitcnt == 4'd7) begin
                        if (state == LK_ADDR) begin
                            if (shreg == {DEV_PREFIX, strap}) begin
                                state    <= sda ? LK_READ : LK_WRITE;
                                ack_pend <= 1'b1;
                            end else begin
                                state <= LK_SKIP;
                            end
                        end else if (state == LK_WRITE) begin
                            wr_valid <= 1'b1;
                            wr_byte  <= {shreg, sda};
                            ack_pend <= 1'b1;
                        end
                    end
                end
            end else if (scl_fall) begin
                if (bitcnt == 4'd8) begin
                    sda_low <= ack_pend;
                end else if (bitcnt == 4'd0) begin
                    ack_pend <= 1'b0;
                    if (state == LK_READ) begin
                        tx      <= status;
                        sda_low <= ~status[7];
                    end else begin
                        sda_low <= 1'b0;
                    end
                end else if (state == LK_READ) begin
                    sda_low <= ~tx[3'd7 - bitcnt[2:0]];
                end
            end
        end
    end
endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
    import tuner_i2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [7:0]       wr_byte,
    input  logic             frame_mark,
    input  logic             supply_low,
    input  logic             read_end,
    output logic [DIV_W-1:0] div_ratio,
    output tune_ctrl_t       ctrl,
    output logic             por_flag
);
    localparam int HI_W = DIV_W - 8;

    logic       second_half;
    logic [7:0] first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_ratio   <= '0;
            ctrl        <= '0;
            second_half <= 1'b0;
            first_q     <= '0;
            por_flag    <= 1'b1;
        end else begin
            if (frame_mark) begin
                second_half <= 1'b0;
            end else if (wr_valid) begin
                if (!second_half) begin
                    first_q     <= wr_byte;
                    second_half <= 1'b1;
                end else begin
                    second_half <= 1'b0;
                    if (first_q[7]) begin
                        ctrl.pump_hi   <= first_q[6];
                        ctrl.test_mode <= first_q[5:4];
                        ctrl.tune_off  <= first_q[0];
                        ctrl.band_uhf  <= wr_byte[7];
                        ctrl.port_drv  <= wr_byte[2:0];
                    end else begin
                        div_ratio <= {first_q[HI_W-1:0], wr_byte};
                    end
                end
            end
            if (supply_low) begin
                por_flag <= 1'b1;
            end else if (read_end) begin
                por_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tuner_i2c_target.sv
module tuner_i2c_target
    import tuner_i2c_pkg::*;
#(
    parameter int FILTER_CYC = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         scl_in,
    input  logic         sda_in,
    output logic         sda_drive_low,
    input  logic [1:0]   strap_addr,
    input  logic         supply_low,
    input  logic         lock_in,
    input  logic [1:0]   ttl_in,
    input  logic [2:0]   adc_code,
    output logic [14:0]  div_ratio,
    output logic         pump_hi,
    output logic [1:0]   test_mode,
    output logic         tune_off,
    output logic         band_uhf,
    output logic [2:0]   port_drv
);
    logic        scl_clean, sda_clean;
    logic        wr_valid, frame_mark, read_end, por_flag;
    logic [7:0]  wr_byte;
    link_state_t link_state;
    tune_ctrl_t  ctrl;
    logic [7:0]  status;

    logic [1:0] raw_lines, clean_lines;
    assign raw_lines = {scl_in, sda_in};
    assign scl_clean = clean_lines[1];
    assign sda_clean = clean_lines[0];

    for (genvar g = 0; g < 2; g++) begin : g_line
        tuner_i2c_deglitch #(.STABLE_CYC(FILTER_CYC), .IDLE_VAL(1'b1)) u_flt (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_lines[g]),
            .clean (clean_lines[g])
        );
    end

    assign status = pack_status(por_flag, lock_in, ttl_in, adc_code);

    tuner_i2c_link u_link (
        .clk        (clk),
        .rst        (rst),
        .scl        (scl_clean),
        .sda        (sda_clean),
        .strap      (strap_addr),
        .status     (status),
        .sda_low    (sda_drive_low),
        .wr_valid   (wr_valid),
        .wr_byte    (wr_byte),
        .frame_mark (frame_mark),
        .read_end   (read_end),
        .state      (link_state)
    );

    tuner_i2c_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .wr_byte    (wr_byte),
        .frame_mark (frame_mark),
        .supply_low (supply_low),
        .read_end   (read_end),
        .div_ratio  (div_ratio),
        .ctrl       (ctrl),
        .por_flag   (por_flag)
    );

    assign pump_hi   = ctrl.pump_hi;
    assign test_mode = ctrl.test_mode;
    assign tune_off  = ctrl.tune_off;
    assign band_uhf  = ctrl.band_uhf;
    assign port_drv  = ctrl.port_drv;
endmodule

// File: rtl/tuner_i2c_target_chk.sv
module tuner_i2c_target_chk
    import tuner_i2c_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        sda_drive_low,
    input logic        scl_clean,
    input logic        wr_valid,
    input link_state_t link_state,
    input logic        por_flag,
    input logic        read_end,
    input logic        supply_low,
    input logic [14:0] div_ratio
);
    // R2
    sda_quiet_in_reset_chk: assert property (@(posedge clk)
        rst |=> !sda_drive_low);

    // R7
    pull_starts_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_drive_low) |-> !scl_clean);

    // R1
    pull_only_when_selected_chk: assert property (@(posedge clk) disable iff (rst)
        sda_drive_low |-> (link_state == LK_WRITE || link_state == LK_READ));

    // R6
    div_moves_on_byte_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_ratio) |-> $past(wr_valid));

    // R9
    por_clears_on_read_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(por_flag) |-> $past(read_end));

    // R10
    por_sets_on_supply_chk: assert property (@(posedge clk) disable iff (rst)
        supply_low |=> por_flag);
endmodule

bind tuner_i2c_target tuner_i2c_target_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .sda_drive_low (sda_drive_low),
    .scl_clean     (scl_clean),
    .wr_valid      (wr_valid),
    .link_state    (link_state),
    .por_flag      (por_flag),
    .read_end      (read_end),
    .supply_low    (supply_low),
    .div_ratio     (div_ratio)
);

// File: tb/tuner_i2c_target_test.sv
`timescale 1ns/1ps
module tuner_i2c_target_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_drive_low;
    logic [1:0]  strap_addr = 2'b10;
    logic        supply_low = 1'b0;
    logic        lock_in = 1'b1;
    logic [1:0]  ttl_in = 2'b01;
    logic [2:0]  adc_code = 3'b011;
    logic [14:0] div_ratio;
    logic        pump_hi, tune_off, band_uhf;
    logic [1:0]  test_mode;
    logic [2:0]  port_drv;

    int total = 0;
    int bad = 0;
    bit busy = 1'b1;

    // reference model state
    logic [14:0] e_div = '0;
    logic        e_pump = 1'b0, e_tune = 1'b0, e_band = 1'b0;
    logic [1:0]  e_test = '0;
    logic [2:0]  e_port = '0;
    int          m_phase = 0;
    logic [7:0]  m_first = '0;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_drive_low;

    tuner_i2c_target uut (
        .clk (clk), .rst (rst), .scl_in (scl_m), .sda_in (sda_line),
        .sda_drive_low (sda_drive_low), .strap_addr (strap_addr),
        .supply_low (supply_low), .lock_in (lock_in), .ttl_in (ttl_in),
        .adc_code (adc_code), .div_ratio (div_ratio), .pump_hi (pump_hi),
        .test_mode (test_mode), .tune_off (tune_off), .band_uhf (band_uhf),
        .port_drv (port_drv)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock comparison of the register outputs against the model (R3 R4 R5 R6)
    always @(negedge clk) begin
        if (!rst && !busy) begin
            total++;
            if (div_ratio !== e_div ||
                {pump_hi, test_mode, tune_off, band_uhf, port_drv} !==
                {e_pump, e_test, e_tune, e_band, e_port}) begin
                bad++;
                $display("FAIL R3/R4 regs actual=%0h/%0h expected=%0h/%0h", div_ratio,
                         {pump_hi, test_mode, tune_off, band_uhf, port_drv}, e_div,
                         {e_pump, e_test, e_tune, e_band, e_port});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic model_byte(input logic [7:0] b);
        if (m_phase == 0) begin
            m_first = b;
            m_phase = 1;
        end else begin
            m_phase = 0;
            if (m_first[7]) begin
                e_pump = m_first[6];
                e_test = m_first[5:4];
                e_tune = m_first[0];
                e_band = b[7];
                e_port = b[2:0];
            end else begin
                e_div = {m_first[6:0], b};
            end
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(20);
        sda_m = 1'b0; tick(20);
        scl_m = 1'b0; tick(10);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(10);
        scl_m = 1'b1; tick(20);
        sda_m = 1'b1; tick(20);
        m_phase = 0;
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        sda_m = b;
        if (glitch) begin
            tick(4); scl_m = 1'b1; tick(1); scl_m = 1'b0; tick(5);
        end else begin
            tick(10);
        end
        scl_m = 1'b1; tick(20);
        scl_m = 1'b0; tick(10);
    endtask

    task automatic write_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i], glitch && i == 7);
        sda_m = 1'b1; tick(10);
        scl_m = 1'b1; tick(10);
        @(negedge clk);
        acked = (sda_line == 1'b0);
        tick(10);
        scl_m = 1'b0; tick(10);
    endtask

    task automatic read_byte(input bit host_ack, output logic [7:0] v);
        v = '0;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; tick(10);
            scl_m = 1'b1; tick(10);
            @(negedge clk);
            v = {v[6:0], sda_line};
            tick(10);
            scl_m = 1'b0; tick(10);
        end
        send_bit(host_ack ? 1'b0 : 1'b1, 1'b0);
    endtask

    // write transaction; n data bytes follow the address
    task automatic write_txn(input logic [7:0] addr, input logic [7:0] b0, b1, b2, b3,
                             input int n, input bit expect_ack, input bit glitch,
                             input string req);
        bit ack;
        logic [7:0] d [4];
        d[0] = b0; d[1] = b1; d[2] = b2; d[3] = b3;
        busy = 1'b1;
        bus_start();
        write_byte(addr, 1'b0, ack);
        check(ack == expect_ack, {req, " address ack"}, ack, expect_ack);
        for (int i = 0; i < n; i++) begin
            write_byte(d[i], glitch && i == 0, ack);
            check(ack == expect_ack, {req, " R7 data ack"}, ack, expect_ack);
            if (expect_ack) model_byte(d[i]);
        end
        bus_stop();
        tick(20);
        busy = 1'b0;
        tick(10);
    endtask

    initial begin
        logic [7:0] v;
        bit ack;
        tick(5);
        // R2 reset state
        check(sda_drive_low == 1'b0, "R2 sda in reset", sda_drive_low, 0);
        check(div_ratio == 15'd0, "R2 divider reset", div_ratio, 0);
        check({pump_hi, test_mode, tune_off, band_uhf, port_drv} == 8'd0,
              "R2 control reset", {pump_hi, test_mode, tune_off, band_uhf, port_drv}, 0);
        rst = 1'b0;
        tick(30);
        busy = 1'b0;

        // R3 divider pair
        write_txn(8'hC4, 8'h12, 8'h34, 8'h00, 8'h00, 2, 1'b1, 1'b0, "R1");
        check(div_ratio == 15'h1234, "R3 divider", div_ratio, 15'h1234);

        // R4 control pair
        write_txn(8'hC4, 8'hEF, 8'h85, 8'h00, 8'h00, 2, 1'b1, 1'b0, "R1");
        check({pump_hi, test_mode, tune_off} == 4'b1101, "R4 control byte one",
              {pump_hi, test_mode, tune_off}, 4'b1101);
        check({band_uhf, port_drv} == 4'b1101, "R4 control byte two",
              {band_uhf, port_drv}, 4'b1101);

        // R5 control then divider, then divider then control
        write_txn(8'hC4, 8'h8E, 8'h02, 8'h7F, 8'hFF, 4, 1'b1, 1'b0, "R5");
        check(div_ratio == 15'h7FFF && pump_hi == 1'b0 && port_drv == 3'b010,
              "R5 control then divider", div_ratio, 15'h7FFF);
        write_txn(8'hC4, 8'h01, 8'h00, 8'hDE, 8'h07, 4, 1'b1, 1'b0, "R5");
        check(div_ratio == 15'h0100 && test_mode == 2'b01 && port_drv == 3'b111,
              "R5 divider then control", div_ratio, 15'h0100);

        // R1 wrong address: no ack, nothing written
        write_txn(8'hC0, 8'h22, 8'h22, 8'h00, 8'h00, 2, 1'b0, 1'b0, "R1");
        check(div_ratio == 15'h0100, "R1 foreign address ignored", div_ratio, 15'h0100);

        // R6 lone first byte then stop
        write_txn(8'hC4, 8'h05, 8'h00, 8'h00, 8'h00, 1, 1'b1, 1'b0, "R6");
        check(div_ratio == 15'h0100, "R6 half pair ignored", div_ratio, 15'h0100);
        write_txn(8'hC4, 8'h05, 8'h55, 8'h00, 8'h00, 2, 1'b1, 1'b0, "R6");
        check(div_ratio == 15'h0555, "R6 fresh pair after stop", div_ratio, 15'h0555);

        // R11 short SCL pulse inside a low phase
        write_txn(8'hC4, 8'h2A, 8'hC3, 8'h00, 8'h00, 2, 1'b1, 1'b1, "R11");
        check(div_ratio == 15'h2AC3, "R11 glitch ignored", div_ratio, 15'h2AC3);

        // R8 read streams status while host acks; R9 nack ends it
        busy = 1'b1;
        bus_start();
        write_byte(8'hC5, 1'b0, ack);
        check(ack == 1'b1, "R8 read address ack", ack, 1);
        read_byte(1'b1, v);
        check(v == 8'hCB, "R8 first status byte", v, 8'hCB);
        read_byte(1'b0, v);
        check(v == 8'hCB, "R8 repeated status byte", v, 8'hCB);
        tick(5);
        check(sda_drive_low == 1'b0, "R9 release after nack", sda_drive_low, 0);
        bus_stop();
        tick(20);

        lock_in = 1'b0; ttl_in = 2'b10; adc_code = 3'b100;
        bus_start();
        write_byte(8'hC5, 1'b0, ack);
        read_byte(1'b0, v);
        check(v == 8'h14, "R9 power-on flag cleared", v, 8'h14);
        bus_stop();
        tick(20);

        // R10 supply-low event
        @(negedge clk) supply_low = 1'b1;
        @(negedge clk) supply_low = 1'b0;
        bus_start();
        write_byte(8'hC5, 1'b0, ack);
        read_byte(1'b0, v);
        check(v == 8'h94, "R10 power-on flag set again", v, 8'h94);
        bus_stop();
        tick(20);
        busy = 1'b0;

        // R1 new strap value moves the address
        strap_addr = 2'b01;
        tick(5);
        write_txn(8'hC2, 8'h00, 8'h77, 8'h00, 8'h00, 2, 1'b1, 1'b0, "R1");
        check(div_ratio == 15'h0077, "R1 strap address", div_ratio, 15'h0077);
        write_txn(8'hC4, 8'h01, 8'h01, 8'h00, 8'h00, 2, 1'b0, 1'b0, "R1");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule